// File: doc/BRIEF.md
# Update-Coalescing Front Cache for Counter Updates

This block sits between a source of counter updates and a multi-bank counter updater. Each update carries a counter address and a signed delta. The block keeps up to `DEPTH` pending updates in a fully associative store. An update whose address is already resident is added into that entry. An update whose address is not resident takes a new slot at the tail. When every slot is full, the oldest entry leaves through a valid/ready eviction port, and its slot takes the new address.

Entries leave strictly in allocation order, and hits do not refresh their age. As a result, one address can reach the banks at most once per `DEPTH` accepted updates. This bounds the load that a stream hammering one counter can put on a single bank. Hit rate is not the goal.

A level-sensitive flush input drains the store one entry per handshake, oldest first, until it is empty. Updates may still arrive during a flush. If an update matches the entry that is leaving in that same cycle, it opens a fresh entry, so no delta is lost.

Top module: `upd_coalesce_cache`

## Requirements
- R1: After reset, `empty_o` is 1, `ev_valid_o` is 0 and `upd_ready_o` is 1.
- R2: An update whose address matches a resident entry that is not leaving in that cycle is accepted in that cycle. Its delta, sign-extended, is added to that entry. Occupancy does not change and nothing is evicted.
- R3: An update whose address is not resident, arriving while a slot is free, is accepted at once. It becomes the newest entry with its sign-extended delta, and nothing is evicted.
- R4: Outside a flush, a non-resident update that arrives while all `DEPTH` slots are occupied raises `ev_valid_o` in the same cycle, with the oldest entry's address and accumulated delta. The update is accepted only in a cycle where `ev_ready_i` is 1, and it then becomes the newest entry.
- R5: While `ev_valid_o` is 1 and `ev_ready_i` is 0, no entry leaves, `ev_addr_o` holds its value into the next cycle, and a capacity-evicting update sees `upd_ready_o` at 0.
- R6: Entries leave in the order in which they were allocated. Hits never change that order.
- R7: Deltas are two's complement, `DELTA_W` bits wide, accumulated modulo 2^`ACC_W`. An entry whose total is zero is still emitted.
- R8: While `flush_i` is 1 and the store is not empty, `ev_valid_o` is 1 with the oldest entry, and one entry leaves on each cycle that `ev_ready_i` is 1. `empty_o` is 1 exactly when no entry is resident, and `ev_valid_o` is then 0.
- R9: During a flush, an update that matches the oldest entry in a cycle where that entry leaves is allocated as a new entry at the tail. If the oldest entry does not leave in that cycle, the update is folded into it instead. At most one entry ever matches a given address.
- R10: Outside a flush, two evictions of the same address are separated by at least `DEPTH` accepted updates.
- R11: After a full drain, the sum of the evicted deltas for each address equals the sum of the accepted input deltas for that address, modulo 2^`ACC_W`.
- R12: Cycles with `upd_valid_i` at 0 and `flush_i` at 0 change no state and evict nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Update present |
| upd_ready_o | output | 1 | Update accepted this cycle when valid |
| upd_addr_i | input | ADDR_W | Counter address of the update |
| upd_delta_i | input | DELTA_W | Signed delta of the update |
| flush_i | input | 1 | Level request to drain all entries |
| ev_valid_o | output | 1 | Evicted entry present |
| ev_ready_i | input | 1 | Downstream updater takes the evicted entry |
| ev_addr_o | output | ADDR_W | Address of the evicted entry |
| ev_delta_o | output | ACC_W | Accumulated signed delta of the evicted entry |
| empty_o | output | 1 | No entry resident |

## Verification
The assertions assume that the inputs hold still between the clock edges, and that an update which is not accepted is not counted as delivered. The stall properties also assume that `ev_ready_i` and `flush_i` are free to change in any cycle. The stimulus changes every input only at the falling edge. The scoreboard credits an update only in a cycle where it sees valid and ready together. The random phase hammers a small address set with ready dropping at random, which keeps the store full and drives the capacity-eviction path. Flushes are interleaved with updates aimed at the leaving entry, and `ev_ready_i` toggles during them.

// File: rtl/ucc_pkg.sv
package ucc_pkg;
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_CAPACITY = 2'd1,
    EV_FLUSH    = 2'd2
  } ev_cause_e;
endpackage

// File: rtl/ucc_cam.sv
module ucc_cam #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             vld_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0] tag_i,
  input  logic [ADDR_W-1:0]            key_i,
  input  logic [IDX_W-1:0]             head_i,
  input  logic                         head_pop_i,
  output logic [DEPTH-1:0]             hit_vec_o,
  output logic                         hit_any_o,
  output logic                         hit_eff_o,
  output logic [IDX_W-1:0]             hit_idx_o
);
  logic [DEPTH-1:0] head_oh;
  logic [DEPTH-1:0] live_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_vec_o[i] = vld_i[i] && (tag_i[i] == key_i);
    assign head_oh[i]   = (head_i == IDX_W'(i));
  end

  // a match on the slot leaving this cycle does not count as a hit
  assign live_vec  = hit_vec_o & ~(head_oh & {DEPTH{head_pop_i}});
  assign hit_any_o = |hit_vec_o;
  assign hit_eff_o = |live_vec;

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live_vec[i]) hit_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/ucc_ring.sv
module ucc_ring #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] occ_o,
  output logic             full_o,
  output logic             empty_o
);
  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
      occ_o  <= '0;
    end else begin
      if (pop_i)  head_o <= nxt(head_o);
      if (push_i) tail_o <= nxt(tail_o);
      case ({push_i, pop_i})
        2'b10:   occ_o <= occ_o + 1'b1;
        2'b01:   occ_o <= occ_o - 1'b1;
        default: occ_o <= occ_o;
      endcase
    end
  end

  assign full_o  = (occ_o == CNT_W'(DEPTH));
  assign empty_o = (occ_o == '0);
endmodule

// File: rtl/ucc_store.sv
module ucc_store #(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 8,
  parameter int DELTA_W = 16,
  parameter int ACC_W   = 24,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  logic [IDX_W-1:0]             tail_i,
  input  logic                         pop_i,
  input  logic [IDX_W-1:0]             head_i,
  input  logic                         fold_i,
  input  logic [IDX_W-1:0]             fold_idx_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DELTA_W-1:0]           delta_i,
  output logic [DEPTH-1:0]             vld_o,
  output logic [DEPTH-1:0][ADDR_W-1:0] tag_o,
  output logic [ADDR_W-1:0]            head_addr_o,
  output logic [ACC_W-1:0]             head_acc_o
);
  logic [DEPTH-1:0][ACC_W-1:0] acc_q;
  logic [ACC_W-1:0]            delta_sx;

  assign delta_sx = {{(ACC_W - DELTA_W){delta_i[DELTA_W-1]}}, delta_i};

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[i] <= 1'b0;
        tag_o[i] <= '0;
        acc_q[i] <= '0;
      end else if (push_i && tail_i == IDX_W'(i)) begin
        // push wins over pop: a full-store eviction reuses the slot
        vld_o[i] <= 1'b1;
        tag_o[i] <= addr_i;
        acc_q[i] <= delta_sx;
      end else if (pop_i && head_i == IDX_W'(i)) begin
        vld_o[i] <= 1'b0;
      end else if (fold_i && fold_idx_i == IDX_W'(i)) begin
        acc_q[i] <= acc_q[i] + delta_sx;
      end
    end
  end

  assign head_addr_o = tag_o[head_i];
  assign head_acc_o  = acc_q[head_i];
endmodule

// File: rtl/upd_coalesce_cache.sv
module upd_coalesce_cache
  import ucc_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 8,
  parameter int DELTA_W = 16,
  parameter int ACC_W   = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_valid_i,
  output logic               upd_ready_o,
  input  logic [ADDR_W-1:0]  upd_addr_i,
  input  logic [DELTA_W-1:0] upd_delta_i,
  input  logic               flush_i,
  output logic               ev_valid_o,
  input  logic               ev_ready_i,
  output logic [ADDR_W-1:0]  ev_addr_o,
  output logic [ACC_W-1:0]   ev_delta_o,
  output logic               empty_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0]             vld;
  logic [DEPTH-1:0][ADDR_W-1:0] tag;
  logic [DEPTH-1:0]             hit_vec;
  logic                         hit_any, hit_eff;
  logic [IDX_W-1:0]             hit_idx, head, tail;
  logic [CNT_W-1:0]             occ;
  logic                         full, empty;
  logic                         pop, push, fold, accept;
  ev_cause_e                    ev_cause;

  always_comb begin
    if (flush_i && !empty)                             ev_cause = EV_FLUSH;
    else if (!flush_i && upd_valid_i && !hit_any && full) ev_cause = EV_CAPACITY;
    else                                               ev_cause = EV_NONE;
  end

  assign ev_valid_o  = (ev_cause != EV_NONE);
  assign pop         = ev_valid_o && ev_ready_i;
  assign upd_ready_o = hit_eff || !full || pop;
  assign accept      = upd_valid_i && upd_ready_o;
  assign push        = accept && !hit_eff;
  assign fold        = accept && hit_eff;
  assign empty_o     = empty;

  ucc_cam #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_cam (
    .vld_i      (vld),
    .tag_i      (tag),
    .key_i      (upd_addr_i),
    .head_i     (head),
    .head_pop_i (pop),
    .hit_vec_o  (hit_vec),
    .hit_any_o  (hit_any),
    .hit_eff_o  (hit_eff),
    .hit_idx_o  (hit_idx)
  );

  ucc_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .head_o  (head),
    .tail_o  (tail),
    .occ_o   (occ),
    .full_o  (full),
    .empty_o (empty)
  );

  ucc_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .ACC_W(ACC_W)
  ) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .tail_i      (tail),
    .pop_i       (pop),
    .head_i      (head),
    .fold_i      (fold),
    .fold_idx_i  (hit_idx),
    .addr_i      (upd_addr_i),
    .delta_i     (upd_delta_i),
    .vld_o       (vld),
    .tag_o       (tag),
    .head_addr_o (ev_addr_o),
    .head_acc_o  (ev_delta_o)
  );
endmodule

// File: rtl/ucc_checker.sv
module ucc_checker #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_valid_i,
  input logic              upd_ready_o,
  input logic              flush_i,
  input logic              ev_valid_o,
  input logic              ev_ready_i,
  input logic [ADDR_W-1:0] ev_addr_o,
  input logic              empty_o,
  input logic [CNT_W-1:0]  occ_i,
  input logic [DEPTH-1:0]  hit_vec_i
);
  p_empty_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !ev_valid_o);

  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_o && !ev_ready_i) |=> $stable(ev_addr_o));

  p_capacity_handshake_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_ready_o && ev_valid_o && !flush_i) |-> ev_ready_i);

  p_hit_keeps_occ_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && (|hit_vec_i) && !flush_i) |=> $stable(occ_i));

  p_idle_keeps_occ_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_valid_i && !flush_i) |=> $stable(occ_i));

  p_flush_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && ev_ready_i && !upd_valid_i && !empty_o) |=> (occ_i + 1'b1 == $past(occ_i)));

  p_single_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_i));
endmodule

bind upd_coalesce_cache ucc_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W($clog2(DEPTH + 1))
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_valid_i (upd_valid_i),
  .upd_ready_o (upd_ready_o),
  .flush_i     (flush_i),
  .ev_valid_o  (ev_valid_o),
  .ev_ready_i  (ev_ready_i),
  .ev_addr_o   (ev_addr_o),
  .empty_o     (empty_o),
  .occ_i       (occ),
  .hit_vec_i   (hit_vec)
);

// File: tb/upd_coalesce_cache_test.sv
`timescale 1ns / 100ps
module upd_coalesce_cache_test;
  localparam int DEPTH   = 8;
  localparam int ADDR_W  = 8;
  localparam int DELTA_W = 16;
  localparam int ACC_W   = 24;
  localparam int NADDR   = 1 << ADDR_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               upd_valid = 1'b0;
  logic               upd_ready;
  logic [ADDR_W-1:0]  upd_addr = '0;
  logic [DELTA_W-1:0] upd_delta = '0;
  logic               flush = 1'b0;
  logic               ev_valid;
  logic               ev_ready = 1'b0;
  logic [ADDR_W-1:0]  ev_addr;
  logic [ACC_W-1:0]   ev_delta;
  logic               empty;

  always #2 clk = ~clk;

  upd_coalesce_cache #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DELTA_W(DELTA_W), .ACC_W(ACC_W)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .upd_valid_i(upd_valid), .upd_ready_o(upd_ready),
    .upd_addr_i(upd_addr), .upd_delta_i(upd_delta),
    .flush_i(flush),
    .ev_valid_o(ev_valid), .ev_ready_i(ev_ready),
    .ev_addr_o(ev_addr), .ev_delta_o(ev_delta),
    .empty_o(empty)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference cache and expected-eviction scoreboard
  logic [ADDR_W-1:0] mq_addr[$];
  logic [ACC_W-1:0]  mq_acc[$];
  logic [ADDR_W-1:0] ex_addr[$];
  logic [ACC_W-1:0]  ex_acc[$];
  logic [ACC_W-1:0]  sum_in [NADDR];
  logic [ACC_W-1:0]  sum_out[NADDR];
  int                last_ev[NADDR];
  int                n_acc = 0;

  function automatic logic [ACC_W-1:0] sx(input logic [DELTA_W-1:0] d);
    return {{(ACC_W - DELTA_W){d[DELTA_W-1]}}, d};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus, predicted from the requirements
  task automatic step(input logic v, input logic [ADDR_W-1:0] a,
                      input logic [DELTA_W-1:0] d, input logic fl, input logic er);
    int  n, idx;
    bit  full, xv, pop, heff, xr;
    @(negedge clk);
    upd_valid = v; upd_addr = a; upd_delta = d; flush = fl; ev_ready = er;
    #1;
    n = mq_addr.size();
    idx = -1;
    for (int k = 0; k < n; k++) if (idx < 0 && mq_addr[k] == a) idx = k;
    full = (n == DEPTH);
    xv   = fl ? (n > 0) : (v && idx < 0 && full);
    pop  = xv && er;
    heff = (idx > 0) || (idx == 0 && !pop);
    xr   = heff || !full || pop;
    chk(upd_ready == xr, "R2/R3/R4/R5", "upd_ready", 32'(upd_ready), 32'(xr));
    chk(ev_valid == xv, "R4/R8/R12", "ev_valid", 32'(ev_valid), 32'(xv));
    chk(empty == (n == 0), "R8", "empty", 32'(empty), 32'(n == 0));
    if (xv) chk(ev_addr == mq_addr[0], "R5/R6", "ev_addr", 32'(ev_addr), 32'(mq_addr[0]));
    if (pop) begin
      ex_addr.push_back(mq_addr.pop_front());
      ex_acc.push_back(mq_acc.pop_front());
      if (idx >= 0) idx--;
    end
    if (v && xr) begin
      sum_in[a] = sum_in[a] + sx(d);
      if (heff) mq_acc[idx] = mq_acc[idx] + sx(d);
      else begin
        mq_addr.push_back(a);
        mq_acc.push_back(sx(d));
      end
    end
  endtask

  task automatic drain(input bit toggle);
    int guard = 0;
    while (mq_addr.size() > 0 && guard < 200) begin
      step(1'b0, '0, '0, 1'b1, toggle ? 1'(guard % 3 != 1) : 1'b1);
      guard++;
    end
    step(1'b0, '0, '0, 1'b0, 1'b1);
  endtask

  // monitor: compare every handshake against the scoreboard
  initial begin
    for (int i = 0; i < NADDR; i++) begin
      sum_in[i] = '0; sum_out[i] = '0; last_ev[i] = -1000000;
    end
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n && upd_valid && upd_ready) n_acc++;
      if (rst_n && flush)
        for (int i = 0; i < NADDR; i++) last_ev[i] = -1000000;
      if (rst_n && ev_valid && ev_ready) begin
        sum_out[ev_addr] = sum_out[ev_addr] + ev_delta;
        if (ex_addr.size() == 0) begin
          chk(1'b0, "R4/R8", "unexpected eviction", 32'(ev_addr), 32'hFFFFFFFF);
        end else begin
          chk(ev_addr == ex_addr[0], "R6", "evicted addr", 32'(ev_addr), 32'(ex_addr[0]));
          chk(ev_delta == ex_acc[0], "R7", "evicted delta", 32'(ev_delta), 32'(ex_acc[0]));
          void'(ex_addr.pop_front());
          void'(ex_acc.pop_front());
        end
        if (!flush) begin
          chk(n_acc - last_ev[ev_addr] >= DEPTH, "R10", "updates between evictions",
              32'(n_acc - last_ev[ev_addr]), 32'(DEPTH));
          last_ev[ev_addr] = n_acc;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(empty == 1'b1, "R1", "empty after reset", 32'(empty), 32'd1);
    chk(ev_valid == 1'b0, "R1", "ev_valid after reset", 32'(ev_valid), 32'd0);
    chk(upd_ready == 1'b1, "R1", "upd_ready after reset", 32'(upd_ready), 32'd1);
    rst_n = 1'b1;

    // R3: fill with distinct addresses
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(10 + i), 16'(i + 1), 1'b0, 1'b1);
    chk(empty == 1'b0, "R3", "empty after fill", 32'(empty), 32'd0);

    // R2 / R7: hits with mixed signs, one entry summing to zero
    step(1'b1, 8'd12, 16'hFFFD, 1'b0, 1'b1);
    step(1'b1, 8'd12, 16'h0002, 1'b0, 1'b1);
    step(1'b1, 8'd10, 16'h7FFF, 1'b0, 1'b1);
    step(1'b1, 8'd10, 16'h7FFF, 1'b0, 1'b1);
    step(1'b1, 8'd11, 16'hFFFE, 1'b0, 1'b0);

    // R12: idle cycles with garbage on the data inputs
    for (int i = 0; i < 4; i++) step(1'b0, 8'd99, 16'h1234, 1'b0, 1'b1);
    chk(ev_valid == 1'b0, "R12", "idle eviction", 32'(ev_valid), 32'd0);

    // R5 then R4: full-store miss held back by downstream
    for (int i = 0; i < 3; i++) step(1'b1, 8'd50, 16'h0005, 1'b0, 1'b0);
    step(1'b1, 8'd50, 16'h0005, 1'b0, 1'b1);
    step(1'b1, 8'd51, 16'h0001, 1'b0, 1'b1);

    // R9: flush with updates aimed at the leaving head
    step(1'b1, mq_addr[0], 16'h0003, 1'b1, 1'b0);  // head stays: folds
    step(1'b1, mq_addr[0], 16'h0004, 1'b1, 1'b1);  // head leaves: new entry
    chk(empty == 1'b0, "R9", "entry reallocated", 32'(empty), 32'd0);
    drain(1'b1);
    chk(empty == 1'b1, "R8", "empty after flush", 32'(empty), 32'd1);

    // R6 / R10: hammer a small address set under random backpressure
    for (int i = 0; i < 600; i++)
      step(1'($urandom_range(0, 4) != 0), 8'($urandom_range(0, 11)),
           16'($urandom), 1'b0, 1'($urandom_range(0, 3) != 0));
    // single hot address: always hits once resident
    for (int i = 0; i < 40; i++) step(1'b1, 8'd3, 16'hFFFF, 1'b0, 1'b1);
    drain(1'b1);

    // R11: conservation per address
    begin
      int bad = 0;
      for (int i = 0; i < NADDR; i++) if (sum_in[i] != sum_out[i]) bad++;
      chk(bad == 0, "R11", "addresses with mismatched sums", 32'(bad), 32'd0);
    end
    chk(ex_addr.size() == 0, "R8", "pending expected evictions", 32'(ex_addr.size()), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule